// File: doc/BRIEF.md
# Serial Bit-Reversal Reorder Buffer

This block takes a serial stream of fixed-length frames, one sample per accepted clock, and hands each frame back out in bit-reversed index order one frame later. It needs only one storage array with as many words as a frame has samples. A single slot counter produces the address. A mode flag decides whether that address is the counter value as it stands or the counter with its bits mirrored. The flag flips each time a frame completes.

For every accepted sample, the addressed word is read into the output register and the incoming sample is then written into the same word. Because the address pattern alternates from frame to frame, the words read in one frame are always the previous frame in bit-reversed order. No second bank is needed.

The block is placed in front of or behind a pipelined transform stage that wants its operands in bit-reversed order. While the first frame fills the array, the output stays marked invalid. After that, every accepted sample yields exactly one output one cycle later. Idle cycles on the input freeze the counter and the mode, so a frame may arrive with gaps.

Top module: `bitrev_reorder`

## Requirements
- R1: After reset, out_valid and out_first are 0, out_data is 0, the slot counter is at slot 0 and the address mode is sequential.
- R2: For the first N accepted samples after reset (N = 2^DEPTH_LOG2), out_valid stays 0.
- R3: From the (N+1)-th accepted sample onward, each sample accepted at a clock edge (in_valid = 1) gives out_valid = 1 after that edge. A cycle with in_valid = 0 gives out_valid = 0 after its edge.
- R4: The output for the sample accepted at slot j (0-based, counted within its frame) of frame k, with k >= 1, is sample rev(j) of frame k-1. Here rev() mirrors the DEPTH_LOG2 index bits, so bit 0 swaps with bit DEPTH_LOG2-1, and so on.
- R5: The address mode flips after every N accepted samples, so R4 holds over any number of back-to-back frames.
- R6: Cycles with in_valid = 0 hold the slot counter and the mode, so frames with gaps are reordered exactly as frames without gaps.
- R7: out_first is 1 exactly together with the valid output produced by slot 0 of a frame, and 0 otherwise.
- R8: in_data is ignored while in_valid = 0; such values never appear on out_data.
- R9: A reset in the middle of a frame restarts the block: the next N accepted samples produce no valid output, and the frame after them is reordered per R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample on in_data is accepted at this edge |
| in_data | input | DATA_W | Incoming sample |
| out_valid | output | 1 | out_data holds a reordered sample |
| out_data | output | DATA_W | Reordered sample, registered |
| out_first | output | 1 | Marks the first output of a reordered frame |

## Verification
The hardest condition to reach is a frame boundary that lands next to an input gap while the mode flag flips. Only then does a counter that drifts during idle cycles, or a mode that toggles at the wrong time, show up as wrongly ordered data. The stimulus streams random frames with in_valid dropped at random, including at the last slot and at slot 0 of a frame. It then resets in the middle of a frame, to confirm that priming and sequential mode come back together.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;

   // Address interpretation for the current frame.
   typedef enum logic {
      ADDR_SEQ = 1'b0,
      ADDR_REV = 1'b1
   } addr_mode_e;

   // Toggle the address interpretation at a frame boundary.
   function automatic addr_mode_e flip_mode(input addr_mode_e m);
      return (m == ADDR_SEQ) ? ADDR_REV : ADDR_SEQ;
   endfunction

endpackage

// File: rtl/bitrev_addr_gen.sv
module bitrev_addr_gen
   import bitrev_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [AW-1:0] slot_cnt,
   output addr_mode_e    rev_mode,
   output logic [AW-1:0] addr,
   output logic          wrap
);

   localparam logic [AW-1:0] LAST_SLOT = {AW{1'b1}};

   logic [AW-1:0] slot_q;
   addr_mode_e    mode_q;
   logic [AW-1:0] mirrored;

   // Mirror the counter bits; a 2:1 select per bit picks the address.
   generate
      for (genvar b = 0; b < AW; b++) begin : g_mirror
         assign mirrored[b] = slot_q[AW-1-b];
         assign addr[b]     = (mode_q == ADDR_REV) ? mirrored[b] : slot_q[b];
      end
   endgenerate

   assign wrap = step && (slot_q == LAST_SLOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         mode_q <= ADDR_SEQ;
      end else if (step) begin
         slot_q <= slot_q + 1'b1;
         if (slot_q == LAST_SLOT) begin
            mode_q <= flip_mode(mode_q);
         end
      end
   end

   assign slot_cnt = slot_q;
   assign rev_mode = mode_q;

endmodule

// File: rtl/bitrev_ram.sv
module bitrev_ram #(
   parameter int AW = 3,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];
   logic [DW-1:0] rdata_q;

   // Storage: write of the new sample into the addressed word.
   always_ff @(posedge clk) begin
      if (en) begin
         mem[addr] <= wdata;
      end
   end

   // Read-first port: the old word is captured at the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (en) begin
         rdata_q <= mem[addr];
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/bitrev_frame_track.sv
module bitrev_frame_track (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic wrap,
   input  logic slot_zero,
   output logic out_valid,
   output logic out_first
);

   logic primed_q;
   logic valid_q;
   logic first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         valid_q  <= 1'b0;
         first_q  <= 1'b0;
      end else begin
         if (wrap) begin
            primed_q <= 1'b1;
         end
         valid_q <= step && primed_q;
         first_q <= step && primed_q && slot_zero;
      end
   end

   assign out_valid = valid_q;
   assign out_first = first_q;

endmodule

// File: rtl/bitrev_reorder.sv
module bitrev_reorder
   import bitrev_pkg::*;
#(
   parameter int DEPTH_LOG2 = 3,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_first
);

   localparam int AW = DEPTH_LOG2;

   generate
      if (DEPTH_LOG2 < 1 || DEPTH_LOG2 > 16) begin : g_bad_depth
         $error("bitrev_reorder: DEPTH_LOG2 must lie in 1..16");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("bitrev_reorder: DATA_W must be at least 1");
      end
   endgenerate

   logic [AW-1:0] slot_cnt;
   addr_mode_e    rev_mode;
   logic [AW-1:0] ram_addr;
   logic          frame_wrap;
   logic          slot_zero;

   bitrev_addr_gen #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (in_valid),
      .slot_cnt (slot_cnt),
      .rev_mode (rev_mode),
      .addr     (ram_addr),
      .wrap     (frame_wrap)
   );

   bitrev_ram #(.AW(AW), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .addr  (ram_addr),
      .wdata (in_data),
      .rdata (out_data)
   );

   assign slot_zero = (slot_cnt == '0);

   bitrev_frame_track u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (in_valid),
      .wrap      (frame_wrap),
      .slot_zero (slot_zero),
      .out_valid (out_valid),
      .out_first (out_first)
   );

endmodule

// File: rtl/bitrev_reorder_chk.sv
module bitrev_reorder_chk
   import bitrev_pkg::*;
#(
   parameter int DEPTH_LOG2 = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  out_valid,
   input logic                  out_first,
   input logic [DEPTH_LOG2-1:0] slot_cnt,
   input addr_mode_e            rev_mode
);

   localparam int CW = DEPTH_LOG2 + 1;
   localparam logic [CW-1:0] FULL = CW'(1) << DEPTH_LOG2;
   localparam logic [DEPTH_LOG2-1:0] LAST = {DEPTH_LOG2{1'b1}};

   // Saturating count of accepted samples since reset.
   logic [CW-1:0] acc_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_cnt <= '0;
      end else if (in_valid && acc_cnt != FULL) begin
         acc_cnt <= acc_cnt + 1'b1;
      end
   end

   AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(acc_cnt) == FULL)); // R2
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc_cnt == FULL) |=> out_valid); // R3
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R3
   AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(slot_cnt) && $stable(rev_mode))); // R6
   AST_MODE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && slot_cnt == LAST) |=> (rev_mode != $past(rev_mode))); // R5
   AST_FIRST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> out_valid); // R7

endmodule

bind bitrev_reorder bitrev_reorder_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_first (out_first),
   .slot_cnt  (slot_cnt),
   .rev_mode  (rev_mode)
);

// File: tb/bitrev_reorder_bench.sv
`timescale 1ns/1ps
module bitrev_reorder_bench;

   localparam int LG = 3;
   localparam int N  = 1 << LG;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic          out_first;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // Bench model state
   logic [DW-1:0] prev_f [N];
   logic [DW-1:0] cur_f  [N];
   int  slot   = 0;
   bit  primed = 1'b0;
   string phase = "R4";

   always #2.5 clk = ~clk;

   bitrev_reorder #(.DEPTH_LOG2(LG), .DATA_W(DW)) u_bitrev_reorder (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_first (out_first)
   );

   function automatic int mirror(input int j);
      int r = 0;
      for (int b = 0; b < LG; b++) begin
         if (j[b]) r |= 1 << (LG - 1 - b);
      end
      return r;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      slot   = 0;
      primed = 1'b0;
   endtask

   // Called at a negedge: drive inputs, let one edge pass, check outputs.
   task automatic step(input bit v, input logic [DW-1:0] d);
      bit            exp_v;
      bit            exp_f;
      logic [DW-1:0] exp_d;
      string         vtag;
      in_valid = v;
      in_data  = d;
      exp_v = v && primed;
      exp_f = exp_v && (slot == 0);
      exp_d = prev_f[mirror(slot)];
      vtag  = (!v) ? ((phase == "R8") ? "R8" : "R6")
                   : (primed ? "R3" : ((phase == "R9") ? "R9" : "R2"));
      if (v) begin
         cur_f[slot] = d;
         slot++;
         if (slot == N) begin
            slot   = 0;
            primed = 1'b1;
            prev_f = cur_f;
         end
      end
      @(posedge clk);
      @(negedge clk);
      check(vtag, int'(out_valid), int'(exp_v));
      check("R7", int'(out_first), int'(exp_f));
      if (exp_v) check(phase, int'(out_data), int'(exp_d));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin : watchdog
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4242));
      for (int i = 0; i < N; i++) begin
         prev_f[i] = '0;
         cur_f[i]  = '0;
      end
      do_reset();
      // R1: reset state at the ports
      check("R1", int'(out_valid), 0);
      check("R1", int'(out_first), 0);
      check("R1", int'(out_data), 0);

      // R2: directed ascending first frame, no output expected
      phase = "R4";
      for (int i = 0; i < N; i++) step(1'b1, DW'(8'h10 + i));
      // R4: second frame reads first in mirrored order
      for (int i = 0; i < N; i++) step(1'b1, DW'(8'h20 + i));

      // R5: back-to-back random frames
      phase = "R5";
      for (int i = 0; i < 6 * N; i++) step(1'b1, DW'($urandom));

      // R6: random gaps, including at frame edges
      phase = "R6";
      for (int i = 0; i < 10 * N; i++) begin
         if (($urandom % 10) < 3) step(1'b0, DW'($urandom));
         else                     step(1'b1, DW'($urandom));
      end
      // directed gap right at the last slot and at slot 0
      while (slot != N - 1) step(1'b1, DW'($urandom));
      step(1'b0, 8'hEE);
      step(1'b1, DW'($urandom));
      step(1'b0, 8'hEE);
      step(1'b0, 8'hEE);
      step(1'b1, DW'($urandom));

      // R8: marker values offered with in_valid low must never show
      phase = "R8";
      for (int i = 0; i < 3 * N; i++) begin
         if (i % 3 == 1) step(1'b0, 8'hA5);
         else            step(1'b1, DW'(i & 8'h7F));
      end
      phase = "R4";
      for (int i = 0; i < 2 * N; i++) step(1'b1, DW'(i & 8'h7F));

      // R9: reset mid-frame, then re-prime and reorder
      step(1'b1, 8'h01);
      step(1'b1, 8'h02);
      step(1'b1, 8'h03);
      do_reset();
      check("R9", int'(out_valid), 0);
      phase = "R9";
      for (int i = 0; i < N; i++) step(1'b1, DW'(8'h40 + i));
      for (int i = 0; i < 2 * N; i++) step(1'b1, DW'($urandom));
      step(1'b0, 8'h00);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule